// File: doc/BRIEF.md
# Serial Flash Page Program Sequencer

This block sits behind a serial-peripheral byte deserializer and carries out the write-enable and page-program commands of a serial flash. It receives whole bytes framed by chip select. It also receives a pulse when chip select rises, with a flag that tells whether that rise landed exactly after the last bit of a byte. From this stream it keeps a write-enable latch and collects up to one page of program data in a local buffer.

When a program frame closes correctly, the block starts a timed busy period. During that period it sweeps the buffer into the array one byte per cycle. Each stored byte becomes the old value AND the new value, so programming can only clear bits. A status byte carries the busy flag and the latch state for the status-read path. A read port lets the neighbouring read logic see the array.

The array is sized by parameters. The default is eight pages so that elaboration stays small. Setting `NUM_PAGES` to 512 gives the full 131,072-byte device.

Top module: `page_prog_seq`

## Requirements
- R1: After reset the status byte is 00h and every array byte reads FFh.
- R2: A frame holding only the byte 06h, closed by a chip-select rise on a byte boundary, sets the write-enable latch. The latch is status bit 1. The same opcode followed by extra bytes, or closed off a boundary, leaves the latch unchanged.
- R3: A committed program stores, at each written location, the previous array byte AND the new data byte.
- R4: A frame that opens with 02h while the write-enable latch is clear changes nothing: neither the array nor the status.
- R5: A program frame is the opcode 02h, then three address bytes most significant first, then data bytes. Address bits [7:0] give the column. The next bits give the page, taken modulo `NUM_PAGES`. Higher address bits are ignored.
- R6: The array changes only after the chip-select rise. A rise that is off a byte boundary, or that comes before any data byte, aborts the program and leaves the array untouched.
- R7: The write-enable latch reads 0 after any program frame that was entered with the latch set, whether the program was committed or aborted.
- R8: Data bytes beyond the end of the page wrap to column 0 of the same page. When a column is written twice in one frame, the later byte is the one that is stored.
- R9: Status bit 0 (busy) reads 1 from the clock edge that samples an accepted chip-select rise, for `max(BUSY_CYCLES, PAGE_BYTES)` cycles. It then reads 0 again.
- R10: While busy, every incoming byte and chip-select rise is ignored, so a write-enable frame sent during busy leaves the latch at 0.
- R11: The opcode 05h and any unknown opcode leave the latch and the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | A received byte is present on byte_data this cycle |
| byte_data | input | 8 | Received byte |
| cs_rise | input | 1 | Single-cycle pulse: chip select has just returned high |
| cs_on_boundary | input | 1 | With cs_rise: the rise followed the last bit of a byte |
| rd_addr | input | MEM_W | Array read address (page, column) |
| rd_data | output | 8 | Array byte at rd_addr |
| status_byte | output | 8 | Bit 0 busy, bit 1 write-enable latch, others 0 |

## Verification
The program path is driven with several frame shapes. Short writes in the middle of a page check address decoding. A second write over already-programmed bytes separates an AND update from a plain overwrite. An over-long frame that starts near the page end checks the column wrap and that the last write wins. An address with high page bits set checks the page modulo. The abort cases differ from a good frame in exactly one respect each: no write-enable, a rise off a boundary, or a rise after the address with no data. These show that the commit condition checks each of those factors. Write-enable frames with extra bytes, frames sent while busy, and the status or unknown opcodes confirm that the latch moves only under the stated conditions.

// File: rtl/pps_pkg.sv
package pps_pkg;

    localparam logic [7:0] OPC_WREN   = 8'h06;
    localparam logic [7:0] OPC_PROG   = 8'h02;
    localparam logic [7:0] OPC_STATUS = 8'h05;

    typedef enum logic [2:0] {
        FS_OPC,
        FS_WREN,
        FS_ADDR,
        FS_DATA,
        FS_SKIP
    } frame_state_e;

endpackage

// File: rtl/pps_frame_ctrl.sv
module pps_frame_ctrl
    import pps_pkg::*;
#(
    parameter int COL_W      = 8,
    parameter int PAGE_W     = 3,
    parameter int ADDR_BYTES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              cs_rise,
    input  logic              cs_on_boundary,
    input  logic              busy,
    output logic              buf_clr,
    output logic              buf_wr,
    output logic [COL_W-1:0]  buf_col,
    output logic [7:0]        buf_din,
    output logic              start,
    output logic [PAGE_W-1:0] start_page,
    output logic              wel
);

    localparam int AIN_W = 8 * ADDR_BYTES;
    localparam int MEM_W = COL_W + PAGE_W;
    localparam int AC_W  = $clog2(ADDR_BYTES + 1);

    typedef struct packed {
        frame_state_e       st;
        logic [AC_W-1:0]    acnt;
        logic [AIN_W-1:0]   addr;
        logic [COL_W-1:0]   col;
        logic [PAGE_W-1:0]  page;
        logic               got_data;
        logic               wel;
    } fc_t;

    fc_t d, q;
    logic [AIN_W-1:0] full_addr;
    logic             unused_addr_hi;

    always_comb begin
        d         = q;
        buf_clr   = 1'b0;
        buf_wr    = 1'b0;
        start     = 1'b0;
        full_addr = (q.addr << 8) | AIN_W'(byte_data);
        unused_addr_hi = ^full_addr[AIN_W-1:MEM_W];
        if (cs_rise) begin
            if (!busy) begin
                if (q.st == FS_WREN && cs_on_boundary) begin
                    d.wel = 1'b1;
                end
                if (q.st == FS_ADDR || q.st == FS_DATA) begin
                    d.wel = 1'b0;
                    if (q.st == FS_DATA && q.got_data && cs_on_boundary) begin
                        start = 1'b1;
                    end
                end
            end
            d.st = FS_OPC;
        end else if (byte_valid) begin
            if (busy) begin
                d.st = FS_SKIP;
            end else begin
                case (q.st)
                    FS_OPC: begin
                        if (byte_data == OPC_WREN) begin
                            d.st = FS_WREN;
                        end else if (byte_data == OPC_PROG && q.wel) begin
                            d.st   = FS_ADDR;
                            d.acnt = '0;
                            d.addr = '0;
                            buf_clr = 1'b1;
                        end else begin
                            d.st = FS_SKIP;
                        end
                    end
                    FS_WREN: d.st = FS_SKIP;
                    FS_ADDR: begin
                        d.addr = full_addr;
                        if (q.acnt == AC_W'(ADDR_BYTES - 1)) begin
                            d.st       = FS_DATA;
                            d.col      = full_addr[COL_W-1:0];
                            d.page     = full_addr[COL_W +: PAGE_W];
                            d.got_data = 1'b0;
                        end else begin
                            d.acnt = q.acnt + 1'b1;
                        end
                    end
                    FS_DATA: begin
                        buf_wr     = 1'b1;
                        d.col      = q.col + 1'b1;
                        d.got_data = 1'b1;
                    end
                    default: d.st = FS_SKIP;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: FS_OPC, default: '0};
        end else begin
            q <= d;
        end
    end

    assign buf_col    = q.col;
    assign buf_din    = byte_data;
    assign start_page = q.page;
    assign wel        = q.wel;

    // R4: a commit is only launched with the latch set
    p_prog_needs_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> q.wel);
    // R6: a commit is only launched by a rise on a byte boundary
    p_start_on_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (cs_rise && cs_on_boundary));
    // R7: the latch is gone after a launched program
    p_wel_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !q.wel);
    // R10: nothing is launched and the latch holds while busy
    p_no_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
    p_wel_frozen_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(q.wel));

endmodule

// File: rtl/pps_page_buf.sv
module pps_page_buf #(
    parameter int PAGE_BYTES = 256,
    parameter int COL_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr,
    input  logic [COL_W-1:0] wcol,
    input  logic [7:0]       wdata,
    input  logic [COL_W-1:0] rcol,
    output logic [7:0]       rdata,
    output logic             rvalid
);

    typedef struct packed {
        logic [PAGE_BYTES-1:0][7:0] data;
        logic [PAGE_BYTES-1:0]      mask;
    } pb_t;

    pb_t d, q;

    always_comb begin
        d = q;
        if (clr) begin
            d.mask = '0;
        end else if (wr) begin
            d.data[wcol] = wdata;
            d.mask[wcol] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rdata  = q.data[rcol];
    assign rvalid = q.mask[rcol];

    // R8: the most recent byte for a column is the one held
    p_last_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr) |=> (q.data[$past(wcol)] == $past(wdata)) && q.mask[$past(wcol)]);

endmodule

// File: rtl/pps_commit.sv
module pps_commit #(
    parameter int PAGE_BYTES = 256,
    parameter int COL_W      = 8,
    parameter int PAGE_W     = 3,
    parameter int BUSY_LEN   = 300
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [PAGE_W-1:0]        start_page,
    input  logic [7:0]               buf_rdata,
    input  logic                     buf_rvalid,
    output logic [COL_W-1:0]         buf_rcol,
    output logic                     busy,
    output logic                     arr_we,
    output logic [COL_W+PAGE_W-1:0]  arr_waddr,
    output logic [7:0]               arr_wdata
);

    localparam int CNT_W = $clog2(BUSY_LEN + 1);

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [PAGE_W-1:0] page;
    } cm_t;

    cm_t d, q;

    always_comb begin
        d         = q;
        buf_rcol  = q.cnt[COL_W-1:0];
        arr_we    = q.busy && (q.cnt < CNT_W'(PAGE_BYTES)) && buf_rvalid;
        arr_waddr = {q.page, q.cnt[COL_W-1:0]};
        arr_wdata = buf_rdata;
        if (q.busy) begin
            if (q.cnt == CNT_W'(BUSY_LEN - 1)) begin
                d.busy = 1'b0;
                d.cnt  = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else if (start) begin
            d.busy = 1'b1;
            d.cnt  = '0;
            d.page = start_page;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy = q.busy;

    // R9: an accepted rise raises busy on the next edge
    p_busy_follows_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !q.busy) |=> q.busy);
    // R9: the busy timer never runs past its length
    p_busy_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.cnt < CNT_W'(BUSY_LEN)));
    // R6: array writes happen only inside the busy window
    p_write_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> q.busy);

endmodule

// File: rtl/pps_array.sv
module pps_array #(
    parameter int DEPTH = 2048,
    parameter int AW    = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [DEPTH-1:0][7:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = mem_q[waddr] & wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '1;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];

    // R3: a write never sets a bit that was clear
    p_only_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((mem_q[$past(waddr)] & ~$past(mem_q[waddr])) == 8'h00));
    // R3: a written location holds no bit the new data had clear
    p_new_zero_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((mem_q[$past(waddr)] & ~$past(wdata)) == 8'h00));

endmodule

// File: rtl/page_prog_seq.sv
module page_prog_seq #(
    parameter int PAGE_BYTES  = 256,
    parameter int NUM_PAGES   = 8,
    parameter int ADDR_BYTES  = 3,
    parameter int BUSY_CYCLES = 300,
    localparam int COL_W    = $clog2(PAGE_BYTES),
    localparam int PAGE_W   = $clog2(NUM_PAGES),
    localparam int MEM_W    = COL_W + PAGE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_valid,
    input  logic [7:0]       byte_data,
    input  logic             cs_rise,
    input  logic             cs_on_boundary,
    input  logic [MEM_W-1:0] rd_addr,
    output logic [7:0]       rd_data,
    output logic [7:0]       status_byte
);

    localparam int DEPTH    = PAGE_BYTES * NUM_PAGES;
    localparam int BUSY_LEN = (BUSY_CYCLES > PAGE_BYTES) ? BUSY_CYCLES : PAGE_BYTES;

    logic              busy, wel, start;
    logic              buf_clr, buf_wr, buf_rvalid;
    logic [COL_W-1:0]  buf_col, buf_rcol;
    logic [7:0]        buf_din, buf_rdata;
    logic [PAGE_W-1:0] start_page;
    logic              arr_we;
    logic [MEM_W-1:0]  arr_waddr;
    logic [7:0]        arr_wdata;

    pps_frame_ctrl #(
        .COL_W(COL_W), .PAGE_W(PAGE_W), .ADDR_BYTES(ADDR_BYTES)
    ) u_frame (
        .clk(clk), .rst_n(rst_n),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .cs_rise(cs_rise), .cs_on_boundary(cs_on_boundary),
        .busy(busy),
        .buf_clr(buf_clr), .buf_wr(buf_wr), .buf_col(buf_col), .buf_din(buf_din),
        .start(start), .start_page(start_page), .wel(wel)
    );

    pps_page_buf #(
        .PAGE_BYTES(PAGE_BYTES), .COL_W(COL_W)
    ) u_buf (
        .clk(clk), .rst_n(rst_n),
        .clr(buf_clr), .wr(buf_wr), .wcol(buf_col), .wdata(buf_din),
        .rcol(buf_rcol), .rdata(buf_rdata), .rvalid(buf_rvalid)
    );

    pps_commit #(
        .PAGE_BYTES(PAGE_BYTES), .COL_W(COL_W), .PAGE_W(PAGE_W), .BUSY_LEN(BUSY_LEN)
    ) u_commit (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_page(start_page),
        .buf_rdata(buf_rdata), .buf_rvalid(buf_rvalid), .buf_rcol(buf_rcol),
        .busy(busy),
        .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata)
    );

    pps_array #(
        .DEPTH(DEPTH), .AW(MEM_W)
    ) u_array (
        .clk(clk), .rst_n(rst_n),
        .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
        .raddr(rd_addr), .rdata(rd_data)
    );

    assign status_byte = {6'b000000, wel, busy};

    // R1: status comes out of reset clear
    p_status_reset_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> (status_byte == 8'h00));
    // R10: while busy no second program can be started
    p_single_commit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |-> !$rose(busy));

endmodule

// File: tb/tb_page_prog_seq.sv
module tb_page_prog_seq;

    localparam int PAGE_BYTES  = 256;
    localparam int NUM_PAGES   = 8;
    localparam int ADDR_BYTES  = 3;
    localparam int BUSY_CYCLES = 300;
    localparam int DEPTH       = PAGE_BYTES * NUM_PAGES;
    localparam int MEM_W       = $clog2(DEPTH);
    localparam int BUSY_LEN    = (BUSY_CYCLES > PAGE_BYTES) ? BUSY_CYCLES : PAGE_BYTES;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             byte_valid = 1'b0;
    logic [7:0]       byte_data = 8'h00;
    logic             cs_rise = 1'b0;
    logic             cs_on_boundary = 1'b0;
    logic [MEM_W-1:0] rd_addr = '0;
    logic [7:0]       rd_data;
    logic [7:0]       status_byte;

    always #2.5 clk = ~clk;

    page_prog_seq #(
        .PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES),
        .ADDR_BYTES(ADDR_BYTES), .BUSY_CYCLES(BUSY_CYCLES)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .cs_rise(cs_rise), .cs_on_boundary(cs_on_boundary),
        .rd_addr(rd_addr), .rd_data(rd_data), .status_byte(status_byte)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_tag = "R1";

    // behavioural reference model
    int   m_mem[DEPTH];
    bit   m_wel;
    int   m_rem;
    bit   m_taint;
    int   m_frame[$];
    int   frame_q[$];

    task automatic model_close(input bit busy_pre, input bit bnd);
        int op, addr, pg, col, nd;
        int pbuf[PAGE_BYTES];
        if (busy_pre || m_taint || m_frame.size() == 0) return;
        op = m_frame[0];
        if (op == 8'h06) begin
            if (m_frame.size() == 1 && bnd) m_wel = 1'b1;
        end else if (op == 8'h02 && m_wel) begin
            m_wel = 1'b0;
            if (m_frame.size() >= 2 + ADDR_BYTES && bnd) begin
                addr = 0;
                for (int i = 1; i <= ADDR_BYTES; i++) addr = (addr << 8) | m_frame[i];
                col = addr % PAGE_BYTES;
                pg  = (addr / PAGE_BYTES) % NUM_PAGES;
                for (int j = 0; j < PAGE_BYTES; j++) pbuf[j] = -1;
                nd = m_frame.size() - 1 - ADDR_BYTES;
                for (int i = 0; i < nd; i++)
                    pbuf[(col + i) % PAGE_BYTES] = m_frame[1 + ADDR_BYTES + i];
                for (int j = 0; j < PAGE_BYTES; j++)
                    if (pbuf[j] >= 0) m_mem[pg * PAGE_BYTES + j] &= pbuf[j];
                m_rem = BUSY_LEN;
            end
        end
    endtask

    always @(posedge clk) begin
        bit busy_pre;
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
            m_wel = 1'b0; m_rem = 0; m_taint = 1'b0; m_frame.delete();
        end else begin
            busy_pre = (m_rem > 0);
            if (busy_pre) m_rem--;
            if (cs_rise) begin
                model_close(busy_pre, cs_on_boundary);
                m_frame.delete();
                m_taint = 1'b0;
            end else if (byte_valid) begin
                if (busy_pre) m_taint = 1'b1;
                m_frame.push_back(int'(byte_data));
            end
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // per-cycle status comparison (R2, R7, R9, R10)
    always @(posedge clk) begin
        #1;
        if (rst_n) check({cur_tag, " status"}, int'(status_byte),
                         ((m_wel ? 2 : 0) | ((m_rem > 0) ? 1 : 0)));
    end

    task automatic send_frame(input bit bnd);
        foreach (frame_q[i]) begin
            @(negedge clk); byte_valid = 1'b1; byte_data = frame_q[i][7:0];
        end
        @(negedge clk); byte_valid = 1'b0;
        @(negedge clk); cs_rise = 1'b1; cs_on_boundary = bnd;
        @(negedge clk); cs_rise = 1'b0; cs_on_boundary = 1'b0;
        frame_q.delete();
    endtask

    task automatic prog_frame(input int addr, input int n, input int seed, input bit bnd);
        frame_q.push_back(8'h02);
        frame_q.push_back((addr >> 16) & 8'hFF);
        frame_q.push_back((addr >> 8) & 8'hFF);
        frame_q.push_back(addr & 8'hFF);
        for (int i = 0; i < n; i++) frame_q.push_back((seed * 37 + i * 11 + 5) & 8'hFF);
        send_frame(bnd);
    endtask

    task automatic wren(input bit bnd);
        frame_q.push_back(8'h06);
        send_frame(bnd);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (status_byte[0]) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic check_array(input string tag);
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk); rd_addr = MEM_W'(a);
            #1 check({tag, " array"}, int'(rd_data), m_mem[a]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cur_tag = "R1";
        @(negedge clk);
        check("R1 reset status", int'(status_byte), 0);
        check_array("R1");

        // R4: program without write enable
        cur_tag = "R4";
        prog_frame(24'h000110, 4, 1, 1'b1);
        wait_idle();
        check("R4 wel", int'(status_byte[1]), 0);
        check_array("R4");

        // R2: write enable sets latch; R5, R9: good program mid-page
        cur_tag = "R2";
        wren(1'b1);
        check("R2 wel set", int'(status_byte[1]), 1);
        cur_tag = "R9";
        prog_frame(24'h00010A, 3, 2, 1'b1);
        @(negedge clk);
        check("R9 busy", int'(status_byte[0]), 1);
        // R10: write enable during busy is ignored
        cur_tag = "R10";
        wren(1'b1);
        wait_idle();
        check("R10 wel after busy wren", int'(status_byte[1]), 0);
        check_array("R5");

        // R3: second program over the same bytes ANDs
        cur_tag = "R3";
        wren(1'b1);
        prog_frame(24'h00010A, 3, 9, 1'b1);
        wait_idle();
        check_array("R3");

        // R6, R7: rise off a boundary aborts and clears latch
        cur_tag = "R6";
        wren(1'b1);
        prog_frame(24'h000300, 5, 3, 1'b0);
        wait_idle();
        check("R7 wel after abort", int'(status_byte[1]), 0);
        check_array("R6 off boundary");

        // R6: rise after address only aborts
        wren(1'b1);
        prog_frame(24'h000300, 0, 3, 1'b1);
        wait_idle();
        check("R7 wel after empty", int'(status_byte[1]), 0);
        check_array("R6 no data");

        // R8: overlong frame wraps within page
        cur_tag = "R8";
        wren(1'b1);
        prog_frame(24'h0002FA, 262, 4, 1'b1);
        wait_idle();
        check("R7 wel after commit", int'(status_byte[1]), 0);
        check_array("R8");

        // R5: page bits beyond array wrap; high byte ignored
        cur_tag = "R5";
        wren(1'b1);
        prog_frame(24'hFF0A40, 6, 5, 1'b1);
        wait_idle();
        check_array("R5 page wrap");

        // R11: status and unknown opcodes leave state
        cur_tag = "R11";
        frame_q.push_back(8'h05); send_frame(1'b1);
        frame_q.push_back(8'hAB); frame_q.push_back(8'h00); send_frame(1'b1);
        check("R11 wel", int'(status_byte[1]), 0);
        wren(1'b1);
        frame_q.push_back(8'h05); send_frame(1'b1);
        check("R11 wel kept", int'(status_byte[1]), 1);

        // R2: write enable with trailing byte does nothing (latch first cleared)
        cur_tag = "R2";
        prog_frame(24'h000000, 0, 0, 1'b0);
        frame_q.push_back(8'h06); frame_q.push_back(8'h00); send_frame(1'b1);
        check("R2 extra byte", int'(status_byte[1]), 0);
        wren(1'b0);
        check("R2 off boundary", int'(status_byte[1]), 0);
        check_array("R11");

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule